// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one SDRAM burst, one address per clock. A start pulse captures a start column together with a length code, an ordering select (sequential or interleave), a write flag and a single-write mode flag. From the next cycle on the block emits addresses with a valid flag. A last flag marks the final beat of a burst of finite length.

Sequential bursts count up inside the aligned block of the burst length and wrap within it. Interleave bursts form their low address bits as the start column XOR the beat index. A full-page burst walks the whole row and wraps from the top column back to column 0. It runs until a stop request or a new start ends it.

A stop request ends any burst in progress. A new start replaces a running burst at once. In single-write mode a write burst is cut to one beat, while reads keep their programmed length.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low, and after its release with no start, valid_o and last_o are 0.
- R2: When start_i is high at a rising edge, valid_o is 1 in the following cycle and addr_o equals the captured col_i; each later beat appears one cycle after the previous one.
- R3: Sequential ordering (ilv_i=0): beat b has its low log2(L) bits equal to (col_i + b) mod L and its upper bits equal to those of col_i, where L is the burst length.
- R4: Interleave ordering (ilv_i=1, L of 8 or less): beat b has its low log2(L) bits equal to col_i XOR b and its upper bits equal to those of col_i.
- R5: bl_code_i values 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. Exactly L valid beats are produced, last_o is 1 only on beat L-1, and valid_o is 0 in the cycle after that beat unless a new start arrived.
- R6: bl_code_i = 7 selects full page. The address increments by one per beat over the whole 2^COL_W column range and wraps from the top column to 0. last_o is never set, the burst does not end by itself, and ilv_i is ignored (sequential order is used).
- R7: When stop_i is high at a rising edge with start_i low, valid_o and last_o are 0 from the next cycle until the next start.
- R8: When single_wr_i and wr_i are both high at start, the burst has exactly one beat with last_o set. Reads in that mode, and writes with single_wr_i low, keep the length set by bl_code_i.
- R9: A start during a running burst abandons that burst; the next cycle shows beat 0 of the new burst.
- R10: The reserved bl_code_i values 4, 5 and 6 give a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst with the fields below |
| col_i | input | COL_W | Start column |
| bl_code_i | input | 3 | Length code: 0..3 give 1/2/4/8, 7 gives full page, 4..6 give 1 |
| ilv_i | input | 1 | 1 selects interleave ordering |
| wr_i | input | 1 | 1 marks the burst as a write |
| single_wr_i | input | 1 | 1 limits write bursts to one beat |
| stop_i | input | 1 | End the running burst |
| addr_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | addr_o carries a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is the full-page wrap from the top column to column 0, which from column 0 would take hundreds of beats. The stimulus reaches it by starting full-page bursts a few columns below the row end, with interleave requested, and then stopping them. Random bursts end at random beats, sometimes on the final beat itself. A directed case restarts a burst in mid-flight, so the stop, restart and natural-end paths all meet the counter in non-zero states.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT= 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;

  localparam int unsigned LG_MAX = 3;

  // log2 of the finite burst length; reserved codes collapse to one beat
  function automatic int unsigned len_log2(logic [2:0] code);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 2;
      BL_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);
  logic        one_beat;
  int unsigned lg;

  assign one_beat = wr_i & single_wr_i;
  assign full_o   = (bl_code_i == BL_PAGE) & ~one_beat;
  assign ilv_o    = ilv_i & ~full_o;
  assign lg       = one_beat ? 0 : len_log2(bl_code_i);

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (i < lg);
  end
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;

  assign seq_low = base_i + beat_i;
  assign ilv_low = base_i ^ beat_i;
  // low bits move, upper bits stay with the start column
  assign addr_o  = (base_i & ~mask_i) | ((ilv_i ? ilv_low : seq_low) & mask_i);
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] beat_o,
  output logic             busy_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat_q;
  logic             busy_q;

  assign last_o = busy_q & ~full_i & (beat_q == mask_i);
  assign beat_o = beat_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      beat_q <= '0;
    end else if (stop_i || last_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      beat_q <= beat_q + 1'b1;  // full page wraps at the row end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] addr_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d, mask_q, base_q, beat;
  logic             full_d, full_q, ilv_d, ilv_q, busy, last;

  burst_len_dec #(.COL_W(COL_W)) u_dec (
    .bl_code_i  (bl_code_i),
    .ilv_i      (ilv_i),
    .wr_i       (wr_i),
    .single_wr_i(single_wr_i),
    .mask_o     (mask_d),
    .full_o     (full_d),
    .ilv_o      (ilv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= col_i;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
    end
  end

  beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .mask_i (mask_q),
    .full_i (full_q),
    .beat_o (beat),
    .busy_o (busy),
    .last_o (last)
  );

  col_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i(base_q),
    .beat_i(beat),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .addr_o(addr_o)
  );

  assign valid_o = busy;
  assign last_o  = last;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic             wr_i,
  input logic             single_wr_i,
  input logic             stop_i,
  input logic [COL_W-1:0] addr_o,
  input logic             valid_o,
  input logic             last_o
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !last_o);
  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && addr_o == $past(col_i));
  a_r5_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r5_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);
  a_r5_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !stop_i && !start_i |=> valid_o);
  a_r7_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o && !last_o);
  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && wr_i && single_wr_i |=> last_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .col_i      (col_i),
  .wr_i       (wr_i),
  .single_wr_i(single_wr_i),
  .stop_i     (stop_i),
  .addr_o     (addr_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 9;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0, ilv_i = 1'b0, wr_i = 1'b0, single_wr_i = 1'b0, stop_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic [COL_W-1:0] addr_o;
  logic             valid_o, last_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .wr_i(wr_i), .single_wr_i(single_wr_i),
    .stop_i(stop_i), .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 means full page
  function automatic int exp_len(int code, bit wr, bit sw);
    if (wr && sw) return 1;
    if (code <= 3) return 1 << code;
    if (code == 7) return 0;
    return 1;
  endfunction

  function automatic int exp_addr(int col, int code, bit ilv, bit wr, bit sw, int b);
    int len = exp_len(code, wr, sw);
    int m = (len == 0) ? ROW - 1 : len - 1;
    int low = (ilv && len != 0) ? (col ^ b) : (col + b);
    return (col & ~m & (ROW - 1)) | (low & m);
  endfunction

  task automatic launch(int col, int code, bit ilv, bit wr, bit sw);
    @(negedge clk);
    start_i = 1; col_i = col[COL_W-1:0]; bl_code_i = code[2:0];
    ilv_i = ilv; wr_i = wr; single_wr_i = sw;
    @(negedge clk);
    start_i = 0;
  endtask

  // stop_at < 0: run to the natural end
  task automatic run_burst(int col, int code, bit ilv, bit wr, bit sw, int stop_at, string req);
    int len = exp_len(code, wr, sw);
    launch(col, code, ilv, wr, sw);
    for (int b = 0; ; b++) begin
      check({req, " valid"}, valid_o, 1);
      check({req, " addr"}, addr_o, exp_addr(col, code, ilv, wr, sw, b));
      check({req, " last"}, last_o, (len != 0 && b == len - 1));
      if (b == stop_at) begin
        stop_i = 1;
        @(negedge clk);
        stop_i = 0;
        check("R7 stop valid", valid_o, 0);
        check("R7 stop last", last_o, 0);
        return;
      end
      if (len != 0 && b == len - 1) begin
        @(negedge clk);
        check("R5 end valid", valid_o, 0);
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    while (!done && checks < 120000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    check("R1 reset valid", valid_o, 0);
    check("R1 reset last", last_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", valid_o, 0);

    run_burst(13, 0, 0, 0, 0, -1, "R2 len1");
    run_burst(13, 2, 0, 0, 0, -1, "R3 seq4");
    run_burst(45, 3, 0, 0, 0, -1, "R3 seq8");
    run_burst(45, 3, 1, 0, 0, -1, "R4 ilv8");
    run_burst(6, 1, 1, 0, 0, -1, "R4 ilv2");
    run_burst(511, 3, 0, 1, 0, -1, "R8 write full length");
    run_burst(22, 3, 0, 1, 1, -1, "R8 single write");
    run_burst(22, 3, 0, 0, 1, -1, "R8 read in single mode");
    run_burst(22, 7, 0, 1, 1, -1, "R8 single write page");
    run_burst(9, 5, 0, 0, 0, -1, "R10 reserved5");
    run_burst(9, 6, 1, 0, 0, -1, "R10 reserved6");
    run_burst(505, 7, 1, 0, 0, 20, "R6 page wrap");
    run_burst(0, 7, 0, 0, 0, ROW + 3, "R6 page full row");
    run_burst(40, 3, 0, 0, 0, 2, "R7 stop seq8");
    run_burst(40, 3, 1, 0, 0, 7, "R7 stop on last");

    // R9 restart mid-burst
    launch(3, 3, 0, 0, 0);
    check("R9 pre addr", addr_o, 3);
    @(negedge clk);
    check("R9 pre addr1", addr_o, 4);
    start_i = 1; col_i = 20; bl_code_i = 1; ilv_i = 0; wr_i = 0; single_wr_i = 0;
    @(negedge clk);
    start_i = 0;
    check("R9 restart addr", addr_o, 20);
    check("R9 restart last", last_o, 0);
    @(negedge clk);
    check("R9 restart addr1", addr_o, 21);
    check("R9 restart last1", last_o, 1);
    @(negedge clk);
    check("R9 restart end", valid_o, 0);

    for (int i = 0; i < 300; i++) begin
      int col = $urandom_range(ROW - 1);
      int code = $urandom_range(7);
      bit ilv = $urandom_range(1);
      bit wr = $urandom_range(1);
      bit sw = ($urandom_range(3) == 0);
      int len = exp_len(code, wr, sw);
      int stop_at = -1;
      if (len == 0) stop_at = $urandom_range(60);
      else if ($urandom_range(3) == 0) stop_at = $urandom_range(len - 1);
      run_burst(col, code, ilv, wr, sw, stop_at, "R3 R4 R5 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule